// File: doc/BRIEF.md
# Ternary Digit-Serial Field Multiplier

This block multiplies two elements of GF(3^97). Each element is a polynomial with 97 coefficients, and every coefficient takes a value of 0, 1 or 2. Operands go in and the product comes out on parallel buses. The bus holds one coefficient in each two-bit slot. A one-cycle `start` loads the operands. `busy` stays high while the product is formed, and a one-cycle `done` marks the moment the product appears on `result`.

Inside, a shift-register loop consumes the multiplier operand a group of D coefficients at a time, starting from the most significant group. Each cycle the running sum is multiplied by x^D and reduced modulo x^97 + x^12 + 2. The product of the multiplicand with the current group is then added in. That product is built from D-coefficient slices, and each slice product uses one Karatsuba split: three half-size products replace four. Issue is back to back, so a new operation may start in the same cycle that `done` is high.

Top module: `tfm_mul`

## Requirements
- R1: Each coefficient is encoded in two bits, with 00 meaning 0, 01 meaning 1 and 10 meaning 2. Coefficient i sits at bits [2i+1:2i]. When `done` is high, `result` never holds the code 11.
- R2: When `done` is high, `result` equals op_a·op_b reduced modulo x^97 + x^12 + 2, where op_a and op_b are the operands captured at the accepted start.
- R3: After a start is accepted, `busy` is high for exactly ceil(97/D) cycles (25 with D=4). `done` rises in the cycle in which `busy` falls.
- R4: `done` is high for one cycle only.
- R5: `result` is 0 after reset. It changes only in a cycle where `done` is high, and otherwise holds its value.
- R6: A `start` raised while `busy` is high is ignored, along with the operands that come with it.
- R7: Multiplying by the constant 1 returns the other operand unchanged. Multiplying by 0 returns 0.
- R8: Reduction folds x^97 into 2·x^12 + 1. For example, x^96 · x gives coefficient 1 at position 0, coefficient 2 at position 12, and 0 everywhere else.
- R9: A start raised in the cycle in which `done` is high is accepted, so `busy` is high again in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Requests a new multiplication; taken only while busy is low |
| op_a | input | 194 | Multiplicand, 97 two-bit coefficients |
| op_b | input | 194 | Multiplier, 97 two-bit coefficients |
| busy | output | 1 | High while a product is being formed |
| done | output | 1 | One-cycle pulse when result is updated |
| result | output | 194 | Product, 97 two-bit coefficients |

## Verification
The assertions assume that the operand buses carry only the codes 00, 01 and 10. The code 11 is an unused encoding that the arithmetic does not define. Every operand the bench drives, whether random, all-twos, unit, zero or a single power of x, is built one coefficient at a time from the values 0 to 2. The assertions also assume that `start` is the only trigger. The bench raises it both while the block is busy and in the done cycle, so that the ignore rule and back-to-back issue are both exercised.

// File: rtl/tfm_pkg.sv
// Package: coefficient type and arithmetic over GF(3).
// Assumes every coefficient arrives as 00, 01 or 10. The code 11 is never produced.
package tfm_pkg;

    typedef logic [1:0] trit_t;

    // Sum of two coefficients, mod 3
    function automatic trit_t t_add(input trit_t a, input trit_t b);
        logic [2:0] s;
        s = {1'b0, a} + {1'b0, b};
        if (s >= 3'd3) s = s - 3'd3;
        return s[1:0];
    endfunction

    // Negation mod 3, which is also the same as doubling
    function automatic trit_t t_neg(input trit_t a);
        return (a == 2'd1) ? 2'd2 : (a == 2'd2) ? 2'd1 : 2'd0;
    endfunction

    // Product of two coefficients, mod 3
    function automatic trit_t t_mul(input trit_t a, input trit_t b);
        if (a == 2'd0 || b == 2'd0) return 2'd0;
        return (a == b) ? 2'd1 : 2'd2;
    endfunction

endpackage

// File: rtl/tfm_school.sv
// Schoolbook product of two W-coefficient polynomials over GF(3).
// The output has 2W-1 coefficients. Inputs must hold valid codes only.
module tfm_school #(
    parameter int W = 2
) (
    input  logic [2*W-1:0]       x,
    input  logic [2*W-1:0]       y,
    output logic [2*(2*W-1)-1:0] p
);
    import tfm_pkg::*;

    // Accumulate every cross product into its power slot
    always_comb begin
        p = '0;
        for (int i = 0; i < W; i++) begin
            for (int j = 0; j < W; j++) begin
                p[2*(i+j) +: 2] = t_add(p[2*(i+j) +: 2],
                                        t_mul(x[2*i +: 2], y[2*j +: 2]));
            end
        end
    end
endmodule

// File: rtl/tfm_kara.sv
// D-by-D coefficient product over GF(3).
// An even D takes one Karatsuba split: three half-size schoolbook products.
// An odd D falls back to a plain schoolbook array.
module tfm_kara #(
    parameter int D = 4
) (
    input  logic [2*D-1:0]       x,
    input  logic [2*D-1:0]       y,
    output logic [2*(2*D-1)-1:0] p
);
    import tfm_pkg::*;

    generate
        if (D >= 2 && D % 2 == 0) begin : g_split
            localparam int H  = D / 2;
            localparam int PW = 2 * H - 1;

            logic [2*H-1:0]  xs, ys;
            logic [2*PW-1:0] pl, ph, pm;

            // Add the halves coefficient-wise to feed the middle product
            always_comb begin
                for (int i = 0; i < H; i++) begin
                    xs[2*i +: 2] = t_add(x[2*i +: 2], x[2*(i+H) +: 2]);
                    ys[2*i +: 2] = t_add(y[2*i +: 2], y[2*(i+H) +: 2]);
                end
            end

            tfm_school #(.W(H)) u_lo  (.x(x[2*H-1:0]),   .y(y[2*H-1:0]),   .p(pl));
            tfm_school #(.W(H)) u_hi  (.x(x[2*D-1:2*H]), .y(y[2*D-1:2*H]), .p(ph));
            tfm_school #(.W(H)) u_mid (.x(xs),           .y(ys),           .p(pm));

            // Combine: low + (mid - low - high)·x^H + high·x^D
            always_comb begin
                trit_t mid;
                p = '0;
                for (int k = 0; k < PW; k++) begin
                    mid = t_add(pm[2*k +: 2],
                                t_add(t_neg(pl[2*k +: 2]), t_neg(ph[2*k +: 2])));
                    p[2*k +: 2]     = t_add(p[2*k +: 2], pl[2*k +: 2]);
                    p[2*(k+D) +: 2] = t_add(p[2*(k+D) +: 2], ph[2*k +: 2]);
                    p[2*(k+H) +: 2] = t_add(p[2*(k+H) +: 2], mid);
                end
            end
        end else begin : g_flat
            tfm_school #(.W(D)) u_sb (.x(x), .y(y), .p(p));
        end
    endgenerate
endmodule

// File: rtl/tfm_digit_mul.sv
// Product of an M-coefficient operand with one D-coefficient digit.
// The operand is cut into ceil(M/D) slices of D coefficients, with zero
// padding at the top. Each slice goes through tfm_kara, and the partial
// results are summed at offsets that are multiples of D. The output has
// M+D-1 coefficients.
module tfm_digit_mul #(
    parameter int M = 97,
    parameter int D = 4
) (
    input  logic [2*M-1:0]       a,
    input  logic [2*D-1:0]       d,
    output logic [2*(M+D-1)-1:0] prod
);
    import tfm_pkg::*;

    localparam int N  = (M + D - 1) / D;
    localparam int C  = N * D;
    localparam int PL = M + D - 1;

    logic [2*C-1:0]       a_pad;
    logic [2*(2*D-1)-1:0] part [N];

    // Zero-extend the operand to a whole number of slices
    always_comb begin
        a_pad = '0;
        a_pad[2*M-1:0] = a;
    end

    generate
        for (genvar g = 0; g < N; g++) begin : g_slice
            tfm_kara #(.D(D)) u_k (.x(a_pad[2*D*g +: 2*D]), .y(d), .p(part[g]));
        end
    endgenerate

    // Overlap-add the slice products; padding keeps the slots above PL at zero
    always_comb begin
        prod = '0;
        for (int g = 0; g < N; g++) begin
            for (int k = 0; k < 2*D-1; k++) begin
                if (g*D + k < PL)
                    prod[2*(g*D+k) +: 2] = t_add(prod[2*(g*D+k) +: 2], part[g][2*k +: 2]);
            end
        end
    end
endmodule

// File: rtl/tfm_mul.sv
// GF(3^97) multiplier, digit-serial with the most significant digit first.
// Each busy cycle: acc <= (acc·x^D + a·digit) mod (x^M + x^TAP + 2).
// Assumes D <= M - TAP, so one fold clears the overflow, and valid codes
// on the operands. start is only taken while busy is low.
module tfm_mul #(
    parameter int M   = 97,
    parameter int D   = 4,
    parameter int TAP = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [2*M-1:0] op_a,
    input  logic [2*M-1:0] op_b,
    output logic           busy,
    output logic           done,
    output logic [2*M-1:0] result
);
    import tfm_pkg::*;

    localparam int N  = (M + D - 1) / D;
    localparam int C  = N * D;
    localparam int CW = $clog2(N + 1);

    logic [2*M-1:0]       a_q, acc_q, res_q, nxt;
    logic [2*C-1:0]       b_q;
    logic [CW-1:0]        dig_q;
    logic                 busy_q, done_q;
    logic [2*D-1:0]       digit;
    logic [2*(M+D-1)-1:0] prod;
    logic [2*(M+D)-1:0]   t;

    assign digit = b_q[2*D*dig_q +: 2*D];

    tfm_digit_mul #(.M(M), .D(D)) u_dm (.a(a_q), .d(digit), .prod(prod));

    // Shift acc by one digit, add the digit product, fold the overflow back in
    always_comb begin
        t = '0;
        for (int i = 0; i < M; i++)
            t[2*(i+D) +: 2] = acc_q[2*i +: 2];
        for (int i = 0; i < M+D-1; i++)
            t[2*i +: 2] = t_add(t[2*i +: 2], prod[2*i +: 2]);
        nxt = t[2*M-1:0];
        for (int j = 0; j < D; j++) begin
            nxt[2*j +: 2]       = t_add(nxt[2*j +: 2], t[2*(M+j) +: 2]);
            nxt[2*(j+TAP) +: 2] = t_add(nxt[2*(j+TAP) +: 2], t_neg(t[2*(M+j) +: 2]));
        end
    end

    // Control: accept start, step through the digits, publish the result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q    <= '0;
            b_q    <= '0;
            acc_q  <= '0;
            res_q  <= '0;
            dig_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (busy_q) begin
                acc_q <= nxt;
                if (dig_q == '0) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                    res_q  <= nxt;
                end else begin
                    dig_q <= dig_q - 1'b1;
                end
            end else if (start) begin
                a_q            <= op_a;
                b_q            <= '0;
                b_q[2*M-1:0]   <= op_b;
                acc_q          <= '0;
                dig_q          <= CW'(N - 1);
                busy_q         <= 1'b1;
            end
        end
    end

    assign busy   = busy_q;
    assign done   = done_q;
    assign result = res_q;

    // ---------------- assertions ----------------
    function automatic logic codes_ok(input logic [2*M-1:0] v);
        for (int i = 0; i < M; i++)
            if (v[2*i +: 2] == 2'b11) return 1'b0;
        return 1'b1;
    endfunction

    // Independent count of busy cycles, used to check the run length
    logic [CW-1:0] chk_len;
    always_ff @(posedge clk) begin
        if (!rst_n) chk_len <= '0;
        else        chk_len <= busy_q ? chk_len + 1'b1 : '0;
    end

    p_valid_codes_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> codes_ok(res_q));
    p_busy_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> (chk_len == CW'(N)));
    p_done_at_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> $fell(busy_q));
    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    p_result_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(res_q) |-> done_q);
    p_start_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && start) |=> ($stable(a_q) && $stable(b_q)));
    p_back_to_back_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && start) |=> busy_q);
endmodule

// File: tb/tfm_mul_bench.sv
`timescale 1ns/1ps
module tfm_mul_bench;
    localparam int M   = 97;
    localparam int D   = 4;
    localparam int TAP = 12;
    localparam int N   = (M + D - 1) / D;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [2*M-1:0] op_a = '0, op_b = '0;
    logic           busy, done;
    logic [2*M-1:0] result;

    int errors = 0;
    int checks = 0;
    int cyc    = 0;
    bit cmp_on = 1'b0;

    always #2.5 clk = ~clk;

    tfm_mul #(.M(M), .D(D), .TAP(TAP)) u_tfm_mul (
        .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
        .busy(busy), .done(done), .result(result));

    // Behavioural reference: full product, then reduction from the top down
    function automatic logic [2*M-1:0] ref_mul(input logic [2*M-1:0] a, input logic [2*M-1:0] b);
        int p [2*M-1];
        int c;
        logic [2*M-1:0] r;
        for (int i = 0; i < 2*M-1; i++) p[i] = 0;
        for (int i = 0; i < M; i++)
            for (int j = 0; j < M; j++)
                p[i+j] += int'(a[2*i +: 2]) * int'(b[2*j +: 2]);
        for (int k = 2*M-2; k >= M; k--) begin
            c = p[k] % 3;
            p[k-M]     += c;
            p[k-M+TAP] += 2 * c;
            p[k] = 0;
        end
        for (int i = 0; i < M; i++) r[2*i +: 2] = 2'(p[i] % 3);
        return r;
    endfunction

    function automatic logic [2*M-1:0] rand_el();
        logic [2*M-1:0] v;
        for (int i = 0; i < M; i++) v[2*i +: 2] = 2'($urandom_range(2));
        return v;
    endfunction

    function automatic logic [2*M-1:0] mono(input int pos, input logic [1:0] c);
        logic [2*M-1:0] v = '0;
        v[2*pos +: 2] = c;
        return v;
    endfunction

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic check(input string req, input logic [2*M-1:0] got, input logic [2*M-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, got, exp);
        end
    endtask

    // Cycle model of the control and result, updated at each rising edge
    logic           m_busy = 1'b0, m_done = 1'b0;
    logic [2*M-1:0] m_res = '0, m_pend = '0;
    int             m_left = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 1'b0; m_done = 1'b0; m_res = '0; m_left = 0;
        end else begin
            m_done = 1'b0;
            if (m_busy) begin
                m_left--;
                if (m_left == 0) begin
                    m_busy = 1'b0; m_done = 1'b1; m_res = m_pend;
                end
            end else if (start) begin
                m_busy = 1'b1; m_left = N; m_pend = ref_mul(op_a, op_b);
            end
        end
    end

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (cmp_on) begin
            check("R3 busy", {{(2*M-1){1'b0}}, busy}, {{(2*M-1){1'b0}}, m_busy});
            check("R4 done", {{(2*M-1){1'b0}}, done}, {{(2*M-1){1'b0}}, m_done});
            check("R2/R5 result", result, m_res);
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            summary();
        end
    end

    task automatic issue(input logic [2*M-1:0] a, input logic [2*M-1:0] b);
        while (busy) @(negedge clk);
        start = 1'b1; op_a = a; op_b = b;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output logic [2*M-1:0] r);
        while (!done) @(negedge clk);
        r = result;
    endtask

    initial begin
        logic [2*M-1:0] a, b, c, d, r, twos;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state (R5)
        check("R5 reset result", result, '0);
        check("R3 reset busy", {{(2*M-1){1'b0}}, busy}, '0);
        cmp_on = 1'b1;

        // R7: unit and zero
        a = rand_el();
        issue(mono(0, 2'b01), a); wait_done(r); check("R7 one", r, a);
        issue(a, '0); wait_done(r); check("R7 zero", r, '0);

        // R8: x^96 * x folds to 2x^12 + 1
        issue(mono(M-1, 2'b01), mono(1, 2'b01)); wait_done(r);
        check("R8 fold", r, mono(0, 2'b01) | mono(TAP, 2'b10));

        // R2: all-twos squared
        for (int i = 0; i < M; i++) twos[2*i +: 2] = 2'b10;
        issue(twos, twos); wait_done(r); check("R2 all-twos", r, ref_mul(twos, twos));

        // R1/R2: random operands
        for (int n = 0; n < 20; n++) begin
            a = rand_el(); b = rand_el();
            issue(a, b); wait_done(r);
            check("R2 random", r, ref_mul(a, b));
            for (int i = 0; i < M; i++)
                if (r[2*i +: 2] == 2'b11) check("R1 code", r, ref_mul(a, b) ^ 1);
        end

        // R6: start while busy is ignored
        a = rand_el(); b = rand_el(); c = rand_el(); d = rand_el();
        issue(a, b);
        repeat (3) @(negedge clk);
        start = 1'b1; op_a = c; op_b = d;
        @(negedge clk);
        start = 1'b0;
        wait_done(r); check("R6 ignore", r, ref_mul(a, b));

        // R9: start in the done cycle is taken
        a = rand_el(); b = rand_el(); c = rand_el(); d = rand_el();
        issue(a, b); wait_done(r);
        start = 1'b1; op_a = c; op_b = d;
        @(negedge clk);
        start = 1'b0;
        check("R9 busy again", {{(2*M-1){1'b0}}, busy}, {{(2*M-1){1'b0}}, 1'b1});
        wait_done(r); check("R9 second", r, ref_mul(c, d));

        repeat (3) @(negedge clk);
        summary();
    end
endmodule